// File: doc/BRIEF.md
# Memory Size Probe Engine

This block is a small bus master that finds out whether RAM answers behind a chip select, and how large that RAM is. It does this without destroying the data that is already stored there. After a one-cycle start pulse it drives a single-word memory port. The port has a request, a write enable, a byte address, write data, read data and an acknowledge. When the run is over, the block returns a byte count and pulses a done flag. A result of zero means that no working memory was found.

The probe touches only the two words at byte offsets 0 and 4. Both words are read first and written back before done is raised. A floating data bus can hold the last value driven onto it, and that value could look like memory. To prevent this, each presence pattern written to offset 0 is followed by a different write to offset 4 before offset 0 is read back.

Sizing relies on address aliasing. For each test offset (4, 8, 16 and so on, below the requested maximum) the engine does the following:
- It reads the test word.
- It writes the complement of that word to offset 0.
- It reads both locations again.

When the two reads are equal, the address has wrapped onto offset 0, and the memory size is that offset. Every access has a watchdog, so a chip select that never acknowledges still ends the run, with a result of zero.

Top module: `mem_size_probe`

## Requirements
- R1: After reset, `done` is 0, `mem_req` is 0 and `size_bytes` is 0.
- R2: The words at byte offsets 0 and 4 are read before any write, and written back with their original values before `done` is raised.
- R3: Every write goes to byte offset 0 or byte offset 4. Offsets 8 and above are only ever read.
- R4: The first presence step writes 0x5555AAAA to offset 0 and then 0xAAAA5555 to offset 4, then reads offset 0. If the read is not 0x5555AAAA, the result is 0. A bus that returns the last value written therefore reports 0.
- R5: The second presence step writes 0xAAAA5555 to offset 0 and then 0x5555AAAA to offset 4, then reads offset 0. If the read is not 0xAAAA5555, the result is 0. A memory with data bit 0 stuck at 0 therefore reports 0.
- R6: When memory is present, the result is the first test offset (starting at 4 and doubling) at which the re-read test word equals the re-read word at offset 0. For a memory of 2^k bytes, with 8 <= 2^k < maximum, the result is 2^k.
- R7: If no wrap is found while the test offset is below the maximum size, the result is the maximum size. With a maximum of 4, no sizing step is made at all. `max_size` is sampled on the start pulse.
- R8: A memory of only 4 bytes fails the presence check, because offset 4 aliases offset 0, and reports 0.
- R9: If a request is not acknowledged within `TMO_CYC` cycles, the request is dropped, the result is 0 and `done` is raised. A later start runs normally.
- R10: `done` is high for exactly one cycle per run. `size_bytes` changes only in that cycle and holds its value until the next run ends.
- R11: The address, write enable and write data stay stable while a request waits for its acknowledge. The request falls in the cycle after it is acknowledged, and only one access is outstanding at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert, synchronised release |
| start | input | 1 | One-cycle pulse that begins a probe when idle |
| max_size | input | ADDR_W | Largest size to test in bytes, a power of two, sampled at start |
| mem_req | output | 1 | Access request, held until acknowledged or timed out |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Byte address of the access |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with the acknowledge |
| mem_ack | input | 1 | One-cycle access acknowledge |
| size_bytes | output | ADDR_W | Detected size in bytes, 0 when nothing answered |
| done | output | 1 | One-cycle pulse at the end of a probe |

## Verification
An access completes in a fixed chain of cycles:
- The request rises one cycle after the sequencer issues it.
- The request falls one cycle after the acknowledge.
- The sequencer advances one cycle after that.

A run therefore lasts a number of cycles that depends on the acknowledge latency, which varies between runs. The bench does not predict the exact cycle of `done`. The driver pushes the expected size, and the restore values, into the scoreboard queue. The monitor compares them at the falling edge of the cycle in which `done` is high, and checks on the next falling edge that `done` has dropped and `size_bytes` has kept its value. The watchdog abort is due no earlier than `TMO_CYC` cycles after the request rises, so the bench measures the length of the hung run and checks that lower bound.

// File: rtl/msp_pkg.sv
package msp_pkg;

  localparam int WORD_W = 32;
  localparam logic [WORD_W-1:0] PAT_A = 32'h5555_AAAA;
  localparam logic [WORD_W-1:0] PAT_B = 32'hAAAA_5555;

  typedef enum logic [4:0] {
    ST_IDLE, ST_SAVE0, ST_SAVE4,
    ST_P1W0, ST_P1W4, ST_P1R0,
    ST_P2W0, ST_P2W4, ST_P2R0,
    ST_STEP, ST_TRD, ST_TWC, ST_T0R, ST_TRD2,
    ST_RS0, ST_RS4, ST_DONE
  } seq_st_t;

  // address select for an access
  typedef enum logic [1:0] { AS_ZERO, AS_FOUR, AS_TEST } addr_sel_t;
  // data select for a write
  typedef enum logic [1:0] { DS_PATA, DS_PATB, DS_NOTT, DS_SAVED } data_sel_t;

  typedef struct packed {
    logic      act;
    logic      we;
    addr_sel_t asel;
    data_sel_t dsel;
  } acc_op_t;

endpackage

// File: rtl/probe_op_decode.sv
module probe_op_decode
  import msp_pkg::*;
(
  input  seq_st_t st,
  output acc_op_t op
);

  always_comb begin
    op = '{act: 1'b0, we: 1'b0, asel: AS_ZERO, dsel: DS_PATA};
    unique case (st)
      ST_SAVE0: op = '{act: 1'b1, we: 1'b0, asel: AS_ZERO, dsel: DS_PATA};
      ST_SAVE4: op = '{act: 1'b1, we: 1'b0, asel: AS_FOUR, dsel: DS_PATA};
      ST_P1W0:  op = '{act: 1'b1, we: 1'b1, asel: AS_ZERO, dsel: DS_PATA};
      ST_P1W4:  op = '{act: 1'b1, we: 1'b1, asel: AS_FOUR, dsel: DS_PATB};
      ST_P1R0:  op = '{act: 1'b1, we: 1'b0, asel: AS_ZERO, dsel: DS_PATA};
      ST_P2W0:  op = '{act: 1'b1, we: 1'b1, asel: AS_ZERO, dsel: DS_PATB};
      ST_P2W4:  op = '{act: 1'b1, we: 1'b1, asel: AS_FOUR, dsel: DS_PATA};
      ST_P2R0:  op = '{act: 1'b1, we: 1'b0, asel: AS_ZERO, dsel: DS_PATA};
      ST_TRD:   op = '{act: 1'b1, we: 1'b0, asel: AS_TEST, dsel: DS_PATA};
      ST_TWC:   op = '{act: 1'b1, we: 1'b1, asel: AS_ZERO, dsel: DS_NOTT};
      ST_T0R:   op = '{act: 1'b1, we: 1'b0, asel: AS_ZERO, dsel: DS_PATA};
      ST_TRD2:  op = '{act: 1'b1, we: 1'b0, asel: AS_TEST, dsel: DS_PATA};
      ST_RS0:   op = '{act: 1'b1, we: 1'b1, asel: AS_ZERO, dsel: DS_SAVED};
      ST_RS4:   op = '{act: 1'b1, we: 1'b1, asel: AS_FOUR, dsel: DS_SAVED};
      default:  op = '{act: 1'b0, we: 1'b0, asel: AS_ZERO, dsel: DS_PATA};
    endcase
  end

endmodule

// File: rtl/probe_bus_port.sv
module probe_bus_port
  import msp_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int TMO_CYC = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic              mem_ack,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  output logic              acc_done,
  output logic              acc_tmo,
  output logic [WORD_W-1:0] acc_rdata
);

  localparam int TW = $clog2(TMO_CYC + 1);
  localparam logic [TW-1:0] CNT_LAST = TW'(TMO_CYC - 1);

  logic          busy_q, busy_n;
  logic [TW-1:0] cnt_q, cnt_n;
  logic          load, ack_hit, expire;

  always_comb begin
    load    = go && !busy_q;
    ack_hit = busy_q && mem_ack;
    expire  = busy_q && !mem_ack && (cnt_q == CNT_LAST);
    busy_n  = busy_q;
    cnt_n   = cnt_q;
    if (load) begin
      busy_n = 1'b1;
      cnt_n  = '0;
    end else if (ack_hit || expire) begin
      busy_n = 1'b0;
    end else if (busy_q) begin
      cnt_n  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      cnt_q    <= '0;
      acc_done <= 1'b0;
      acc_tmo  <= 1'b0;
    end else begin
      busy_q   <= busy_n;
      cnt_q    <= cnt_n;
      acc_done <= ack_hit;
      acc_tmo  <= expire;
    end
  end

  // access fields, loaded only when a new access starts
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else if (load) begin
      mem_we    <= we_i;
      mem_addr  <= addr_i;
      mem_wdata <= wdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_rdata <= '0;
    end else if (ack_hit) begin
      acc_rdata <= mem_rdata;
    end
  end

  assign mem_req = busy_q;

endmodule

// File: rtl/probe_seq.sv
module probe_seq
  import msp_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] max_size,
  input  acc_op_t           op,
  input  logic              acc_done,
  input  logic              acc_tmo,
  input  logic [WORD_W-1:0] acc_rdata,
  output seq_st_t           st,
  output logic              go,
  output logic              we,
  output logic [ADDR_W-1:0] addr,
  output logic [WORD_W-1:0] wdata,
  output logic [ADDR_W-1:0] size_bytes,
  output logic              done
);

  localparam logic [ADDR_W-1:0] FIRST_OFS = ADDR_W'(4);

  seq_st_t           st_q, st_n;
  logic              issued_q, issued_n;
  logic [ADDR_W-1:0] ofs_q, ofs_n;
  logic [ADDR_W-1:0] max_q, max_n;
  logic [ADDR_W-1:0] res_q, res_n;
  logic              done_n;
  logic [WORD_W-1:0] save0_q, save4_q, hold_t_q, hold_0_q;
  logic              save0_en, save4_en, hold_t_en, hold_0_en, size_en;

  // access request and operand selection
  always_comb begin
    go = op.act && !issued_q;
    we = op.we;
    unique case (op.asel)
      AS_ZERO: addr = '0;
      AS_FOUR: addr = ADDR_W'(4);
      default: addr = ofs_q;
    endcase
    unique case (op.dsel)
      DS_PATA: wdata = PAT_A;
      DS_PATB: wdata = PAT_B;
      DS_NOTT: wdata = ~hold_t_q;
      default: wdata = (op.asel == AS_FOUR) ? save4_q : save0_q;
    endcase
  end

  // next state
  always_comb begin
    st_n     = st_q;
    issued_n = issued_q;
    ofs_n    = ofs_q;
    max_n    = max_q;
    res_n    = res_q;
    done_n   = 1'b0;
    if (acc_tmo) begin
      issued_n = 1'b0;
      res_n    = '0;
      st_n     = ST_DONE;
    end else if (acc_done) begin
      issued_n = 1'b0;
      unique case (st_q)
        ST_SAVE0: st_n = ST_SAVE4;
        ST_SAVE4: st_n = ST_P1W0;
        ST_P1W0:  st_n = ST_P1W4;
        ST_P1W4:  st_n = ST_P1R0;
        ST_P1R0: begin
          if (acc_rdata == PAT_A) st_n = ST_P2W0;
          else begin
            res_n = '0;
            st_n  = ST_RS0;
          end
        end
        ST_P2W0:  st_n = ST_P2W4;
        ST_P2W4:  st_n = ST_P2R0;
        ST_P2R0: begin
          if (acc_rdata == PAT_B) st_n = ST_STEP;
          else begin
            res_n = '0;
            st_n  = ST_RS0;
          end
        end
        ST_TRD:   st_n = ST_TWC;
        ST_TWC:   st_n = ST_T0R;
        ST_T0R:   st_n = ST_TRD2;
        ST_TRD2: begin
          if (acc_rdata == hold_0_q) begin
            res_n = ofs_q;
            st_n  = ST_RS0;
          end else begin
            ofs_n = ofs_q << 1;
            st_n  = ST_STEP;
          end
        end
        ST_RS0:   st_n = ST_RS4;
        ST_RS4:   st_n = ST_DONE;
        default:  st_n = st_q;
      endcase
    end else begin
      if (go) issued_n = 1'b1;
      unique case (st_q)
        ST_IDLE: begin
          if (start) begin
            ofs_n = FIRST_OFS;
            max_n = max_size;
            res_n = '0;
            st_n  = ST_SAVE0;
          end
        end
        ST_STEP: begin
          if (ofs_q < max_q) st_n = ST_TRD;
          else begin
            res_n = max_q;
            st_n  = ST_RS0;
          end
        end
        ST_DONE: begin
          done_n = 1'b1;
          st_n   = ST_IDLE;
        end
        default: st_n = st_q;
      endcase
    end
  end

  always_comb begin
    save0_en  = acc_done && (st_q == ST_SAVE0);
    save4_en  = acc_done && (st_q == ST_SAVE4);
    hold_t_en = acc_done && (st_q == ST_TRD);
    hold_0_en = acc_done && (st_q == ST_T0R);
    size_en   = (st_q == ST_DONE) && !acc_tmo && !acc_done;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      issued_q <= 1'b0;
      ofs_q    <= '0;
      max_q    <= '0;
      res_q    <= '0;
      done     <= 1'b0;
    end else begin
      st_q     <= st_n;
      issued_q <= issued_n;
      ofs_q    <= ofs_n;
      max_q    <= max_n;
      res_q    <= res_n;
      done     <= done_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      save0_q  <= '0;
      save4_q  <= '0;
      hold_t_q <= '0;
      hold_0_q <= '0;
    end else begin
      if (save0_en)  save0_q  <= acc_rdata;
      if (save4_en)  save4_q  <= acc_rdata;
      if (hold_t_en) hold_t_q <= acc_rdata;
      if (hold_0_en) hold_0_q <= acc_rdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) size_bytes <= '0;
    else if (size_en) size_bytes <= res_q;
  end

  assign st = st_q;

endmodule

// File: rtl/mem_size_probe.sv
module mem_size_probe
  import msp_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int TMO_CYC = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] max_size,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  input  logic              mem_ack,
  output logic [ADDR_W-1:0] size_bytes,
  output logic              done
);

  // reset: asynchronous assert, release through two flops
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  seq_st_t           st;
  acc_op_t           op;
  logic              go, we, acc_done, acc_tmo;
  logic [ADDR_W-1:0] addr;
  logic [WORD_W-1:0] wdata, acc_rdata;

  probe_op_decode u_dec (
    .st (st),
    .op (op)
  );

  probe_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .start      (start),
    .max_size   (max_size),
    .op         (op),
    .acc_done   (acc_done),
    .acc_tmo    (acc_tmo),
    .acc_rdata  (acc_rdata),
    .st         (st),
    .go         (go),
    .we         (we),
    .addr       (addr),
    .wdata      (wdata),
    .size_bytes (size_bytes),
    .done       (done)
  );

  probe_bus_port #(.ADDR_W(ADDR_W), .TMO_CYC(TMO_CYC)) u_port (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .go        (go),
    .we_i      (we),
    .addr_i    (addr),
    .wdata_i   (wdata),
    .mem_ack   (mem_ack),
    .mem_rdata (mem_rdata),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .acc_done  (acc_done),
    .acc_tmo   (acc_tmo),
    .acc_rdata (acc_rdata)
  );

endmodule

// File: rtl/probe_chk.sv
module probe_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [31:0]       mem_wdata,
  input logic              mem_ack,
  input logic [ADDR_W-1:0] size_bytes,
  input logic              done
);

  AST_WR_LOW_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (mem_addr == '0 || mem_addr == ADDR_W'(4))); // R3

  AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> ($stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata))); // R11

  AST_REQ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack) |=> !mem_req); // R11

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10

  AST_SIZE_ONLY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(size_bytes) |-> done); // R10

  AST_SIZE_POW2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($countones(size_bytes) <= 1)); // R6

endmodule

bind mem_size_probe probe_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .mem_req    (mem_req),
  .mem_we     (mem_we),
  .mem_addr   (mem_addr),
  .mem_wdata  (mem_wdata),
  .mem_ack    (mem_ack),
  .size_bytes (size_bytes),
  .done       (done)
);

// File: tb/sim_mem_size_probe.sv
`timescale 1ns/1ps
module sim_mem_size_probe;

  localparam int AW = 32;
  localparam int TMO = 256;
  localparam int M_RAM = 0, M_FLOAT = 1, M_STUCK = 2, M_HANG = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] max_size = '0;
  logic          mem_req, mem_we, mem_ack = 1'b0, done;
  logic [AW-1:0] mem_addr, size_bytes;
  logic [31:0]   mem_wdata, mem_rdata = '0;

  always #2.5 clk = ~clk;

  mem_size_probe #(.ADDR_W(AW), .TMO_CYC(TMO)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .max_size(max_size),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .size_bytes(size_bytes), .done(done)
  );

  // memory model: aliases addresses modulo msize bytes
  int          mode = M_RAM, msize = 1024, lat = 0, wcnt = 0, wr_other = 0;
  logic [31:0] mem [0:1023];
  logic [31:0] bus_last = '0;

  function automatic int widx(logic [31:0] a);
    return int'((a & (msize - 1)) >> 2) & 1023;
  endfunction

  always @(posedge clk) begin
    if (mem_ack) mem_ack <= 1'b0;
    else if (mem_req && mode != M_HANG) begin
      if (wcnt >= lat) begin
        wcnt    <= 0;
        mem_ack <= 1'b1;
        if (mem_we) begin
          if (!(mem_addr == 0 || mem_addr == 4)) wr_other <= wr_other + 1;
          bus_last <= mem_wdata;
          if (mode == M_RAM)   mem[widx(mem_addr)] <= mem_wdata;
          if (mode == M_STUCK) mem[widx(mem_addr)] <= mem_wdata & ~32'h1;
        end else begin
          mem_rdata <= (mode == M_FLOAT) ? bus_last : mem[widx(mem_addr)];
        end
      end else wcnt <= wcnt + 1;
    end
  end

  int n_chk = 0, n_fail = 0, n_done = 0, cyc = 0;
  bit finished = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // scoreboard queues
  logic [31:0] q_size[$];
  string       q_tag[$];
  int          q_rs[$];
  logic [31:0] q_s0[$], q_s4[$], q_s2[$];

  // monitor
  bit prev_done = 0;
  logic [31:0] prev_size = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_done) begin
        chk("R10 done drops after one cycle", {31'd0, done}, 32'd0);
        chk("R10 size held after done", size_bytes, prev_size);
      end
      if (done) begin
        if (q_size.size() == 0) chk("R10 unexpected done", 32'd1, 32'd0);
        else begin
          automatic logic [31:0] es = q_size.pop_front();
          automatic string tg = q_tag.pop_front();
          automatic int rs = q_rs.pop_front();
          automatic logic [31:0] s0 = q_s0.pop_front();
          automatic logic [31:0] s4 = q_s4.pop_front();
          automatic logic [31:0] s2 = q_s2.pop_front();
          chk(tg, size_bytes, es);
          if (rs == 2) begin
            chk("R2 word at offset 0 restored", mem[0], s0);
            chk("R2 word at offset 4 restored", mem[1], s4);
            chk("R3 word at offset 8 untouched", mem[2], s2);
          end else if (rs == 1) begin
            chk("R2 aliased word restored", mem[0], s0);
          end
          chk("R3 no write outside offsets 0 and 4", wr_other, 32'd0);
        end
        n_done++;
      end
      prev_done = done;
      prev_size = size_bytes;
    end
  end

  function automatic logic [31:0] exp_size(int md, int ms, int mx);
    if (md != M_RAM || ms < 8) return 32'd0;
    if (ms < mx) return ms;
    return mx;
  endfunction

  // driver: sets up the model, pushes the expectation, starts a probe
  task automatic run(string tag, int md, int ms, int mx, int lt, output int cycles);
    int d0;
    mode = md; msize = ms; lat = lt; wr_other = 0; bus_last = '0;
    for (int i = 0; i < 1024; i++) mem[i] = 32'h3C00_0000 ^ (i * 32'h0001_9E37);
    q_size.push_back(exp_size(md, ms, mx));
    q_tag.push_back(tag);
    q_rs.push_back((md == M_RAM) ? ((ms >= 8) ? 2 : 1) : 0);
    q_s0.push_back(mem[0]);
    q_s4.push_back(mem[(ms >= 8) ? 1 : 0]);
    q_s2.push_back(mem[2]);
    d0 = n_done;
    @(negedge clk);
    max_size = mx;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cycles = 1;
    while (n_done == d0 && cycles < 20000) begin
      @(negedge clk);
      cycles++;
    end
    if (n_done == d0) chk({tag, " no done"}, 32'd0, 32'd1);
    repeat (3) @(negedge clk);
    chk("R10 size holds while idle", size_bytes, exp_size(md, ms, mx));
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=<150000", cyc);
      finish_run();
    end
  end

  initial begin
    int c;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 done after reset", {31'd0, done}, 32'd0);
    chk("R1 request after reset", {31'd0, mem_req}, 32'd0);
    chk("R1 size after reset", size_bytes, 32'd0);

    run("R6 1KB memory below 4KB limit", M_RAM, 1024, 4096, 0, c);
    run("R6 R11 256B memory with slow acknowledge", M_RAM, 256, 4096, 3, c);
    run("R6 8B smallest sizable memory", M_RAM, 8, 4096, 1, c);
    run("R7 memory equal to limit", M_RAM, 4096, 4096, 0, c);
    run("R7 memory above limit", M_RAM, 4096, 2048, 2, c);
    run("R7 limit 4 skips sizing", M_RAM, 1024, 4, 0, c);
    run("R8 4B memory fails presence", M_RAM, 4, 4096, 0, c);
    run("R4 floating bus rejected", M_FLOAT, 1024, 4096, 0, c);
    run("R5 stuck data bit rejected", M_STUCK, 1024, 4096, 1, c);
    run("R9 unacknowledged access aborts", M_HANG, 1024, 4096, 0, c);
    chk("R9 abort not before watchdog limit", {31'd0, (c >= TMO)}, 32'd1);
    run("R9 normal run after abort", M_RAM, 512, 4096, 1, c);

    chk("R10 scoreboard drained", q_size.size(), 32'd0);
    finish_run();
  end

endmodule